// File: doc/BRIEF.md
# Variable Refresh Vertical Timing Generator

This block counts scanlines for one display transcoder and decides, frame by frame, how long each vertical period lasts. In fixed mode every frame has the programmed total. The register latch point sits at the programmed vblank start line.

In variable mode the frame length floats between a programmed minimum and maximum. Software asks for the end of vertical blank by setting a push request. The block honours that request only inside a window whose lower edge comes from the minimum total and the flip line, and whose upper edge comes from the maximum total. Both edges are pulled back by the vblank-exit length. When the exit begins, the block raises a one-cycle latch strobe. When the exit length has run out, it restarts the counter with a frame-start strobe.

The exit length comes from one of two formulas. In guardband mode it is a programmed line count. In legacy mode it is a capped pipeline-fill count, plus the frame-start delay, plus one extra line. A change to the mode enable is applied only at a frame start. A live status output shows which mode is actually running. The block advances on a single-cycle line tick.

Top module: `vrr_vtg`

## Requirements
- R1: While reset is held and right after it, the line counter reads 0 and the following outputs are all low: frame start, latch, vblank, vblank exit, live status, push enable and push send.
- R2: With live status low, each frame lasts `cfg_vtotal_m1_i`+1 lines. The latch strobe fires at line `cfg_vbl_start_i`. `vblank_o` is high exactly when the line is at or beyond `cfg_vbl_start_i`.
- R3: The minimum, maximum, flip and fixed-total inputs hold the line count minus one. In variable mode the earliest exit line is max(`cfg_vmin_m1_i`+2, `cfg_flip_m1_i`+1) minus the exit length, floored at 0. The latest exit line is `cfg_vmax_m1_i`+1 minus the exit length. With `cfg_legacy_i`=0, the exit length equals `cfg_guardband_i` (0 is treated as 1).
- R4: In variable mode, if no push is pending, the exit starts at the latest exit line. The frame then totals `cfg_vmax_m1_i`+1 lines, and the line never exceeds `cfg_vmax_m1_i`.
- R5: A push that is pending before the earliest exit line is held. The exit then begins at the earliest exit line.
- R6: A push written while the line lies between the earliest and latest exit lines starts the exit on that same line, within two clocks of the write. The frame then totals that line plus the exit length.
- R7: With `cfg_legacy_i`=1, the exit length is min(`cfg_pipe_full_i`,255) + `cfg_fs_delay_i` + 2. The 2-bit delay code 0..3 stands for a frame-start delay of 1..4 lines, and the extra line is included.
- R8: A write on `push_wr_i` loads the enable bit from `push_wr_en_i`. It loads the send bit from `push_wr_send_i` AND `push_wr_en_i`, so writing zero clears both. The send bit clears at the frame start that ends a frame whose exit the push triggered. A push written after the exit has begun stays pending into the next frame.
- R9: A change on `cfg_vrr_en_i` affects nothing until the next frame start. `vrr_live_o` takes the new value on that same cycle.
- R10: While live status is low, a pending push does not change the frame timing, and the send bit stays set.
- R11: On a frame start the counter reads 0 and `frame_start_o` is high for one cycle. `latch_o` is high for one cycle when the exit begins. `vblank_exit_o` stays high from that point to the frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_tick_i | input | 1 | One-cycle pulse per scanline |
| cfg_vrr_en_i | input | 1 | Requested variable mode, applied at frame start |
| cfg_legacy_i | input | 1 | 1: legacy exit-length formula, 0: guardband |
| cfg_vbl_start_i | input | LINE_W | Vblank start line |
| cfg_vtotal_m1_i | input | LINE_W | Fixed-mode total lines minus one |
| cfg_vmin_m1_i | input | LINE_W | Minimum total minus one |
| cfg_vmax_m1_i | input | LINE_W | Maximum total minus one |
| cfg_flip_m1_i | input | LINE_W | Flip line minus one |
| cfg_guardband_i | input | GB_W | Guardband exit length |
| cfg_pipe_full_i | input | PF_W | Pipeline-fill lines (legacy) |
| cfg_fs_delay_i | input | 2 | Frame-start delay code, delay = code+1 |
| push_wr_i | input | 1 | Push register write strobe |
| push_wr_en_i | input | 1 | Push enable value to write |
| push_wr_send_i | input | 1 | Push send value to write |
| line_o | output | LINE_W | Current scanline |
| vblank_o | output | 1 | Vertical blank |
| vblank_exit_o | output | 1 | Vblank exit in progress |
| frame_start_o | output | 1 | Frame start strobe |
| latch_o | output | 1 | Register latch strobe |
| vrr_live_o | output | 1 | Variable mode active |
| push_en_o | output | 1 | Push enable bit readback |
| push_send_o | output | 1 | Push pending readback |

## Verification
The bench drives pushes at four points in the frame: before the window opens, inside it, after the exit has already begun, and during fixed mode. A design that consumed a late push would return a short frame where a full-length one is due. A design that honoured a push in fixed mode would shorten a fixed frame. It also separates a flip line set above the minimum total, which exposes a design that ignores the flip line. A pipeline-fill value above 255 catches a missing cap through a wrong latch line. Toggling the mode enable mid-frame exposes a design that switches live status before the frame boundary.

// File: rtl/vrr_vtg_pkg.sv
package vrr_vtg_pkg;
   typedef enum logic {
      EXIT_GUARDBAND = 1'b0,
      EXIT_LEGACY    = 1'b1
   } exit_mode_e;

   localparam int PIPE_FULL_CAP = 255;
endpackage

// File: rtl/vrr_exit_window.sv
module vrr_exit_window
   import vrr_vtg_pkg::*;
#(
   parameter int LINE_W = 12,
   parameter int GB_W   = 8,
   parameter int PF_W   = 9
) (
   input  exit_mode_e         mode_i,
   input  logic [LINE_W-1:0]  vmin_m1_i,
   input  logic [LINE_W-1:0]  vmax_m1_i,
   input  logic [LINE_W-1:0]  flip_m1_i,
   input  logic [GB_W-1:0]    guardband_i,
   input  logic [PF_W-1:0]    pipe_full_i,
   input  logic [1:0]         fs_delay_i,
   output logic [LINE_W+1:0]  exit_len_o,
   output logic [LINE_W+1:0]  earliest_o,
   output logic [LINE_W+1:0]  latest_o
);
   localparam int EW = LINE_W + 2;

   logic [EW-1:0] pf_eff;
   logic [EW-1:0] len_raw;
   logic [EW-1:0] len;
   logic [EW-1:0] vmin_pt;
   logic [EW-1:0] flip_pt;
   logic [EW-1:0] floor_pt;
   logic [EW-1:0] vmax_pt;

   generate
      if (PF_W > 8) begin : g_pf_cap
         always_comb pf_eff = (pipe_full_i > PF_W'(PIPE_FULL_CAP)) ? EW'(PIPE_FULL_CAP)
                                                                   : EW'(pipe_full_i);
      end else begin : g_pf_direct
         assign pf_eff = EW'(pipe_full_i);
      end
   endgenerate

   always_comb begin
      len_raw  = (mode_i == EXIT_LEGACY) ? (pf_eff + EW'(fs_delay_i) + EW'(2))
                                         : EW'(guardband_i);
      len      = (len_raw == '0) ? EW'(1) : len_raw;
      vmin_pt  = EW'(vmin_m1_i) + EW'(2);
      flip_pt  = EW'(flip_m1_i) + EW'(1);
      floor_pt = (flip_pt > vmin_pt) ? flip_pt : vmin_pt;
      vmax_pt  = EW'(vmax_m1_i) + EW'(1);
      earliest_o = (floor_pt > len) ? (floor_pt - len) : '0;
      latest_o   = (vmax_pt > len) ? (vmax_pt - len) : '0;
      exit_len_o = len;
   end
endmodule

// File: rtl/vrr_push_ctl.sv
module vrr_push_ctl (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic wr_i,
   input  logic wr_en_i,
   input  logic wr_send_i,
   input  logic consume_i,
   input  logic wrap_i,
   output logic en_o,
   output logic send_o,
   output logic pending_o
);
   logic en_q, send_q, used_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q   <= 1'b0;
         send_q <= 1'b0;
         used_q <= 1'b0;
      end else if (wr_i) begin
         en_q   <= wr_en_i;
         send_q <= wr_en_i & wr_send_i;
         used_q <= 1'b0;
      end else begin
         if (consume_i) used_q <= 1'b1;
         if (wrap_i) begin
            used_q <= 1'b0;
            if (used_q) send_q <= 1'b0;
         end
      end
   end

   assign en_o      = en_q;
   assign send_o    = send_q;
   assign pending_o = en_q & send_q;
endmodule

// File: rtl/vrr_line_seq.sv
module vrr_line_seq #(
   parameter int LINE_W = 12
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              vrr_req_i,
   input  logic [LINE_W-1:0] vbl_start_i,
   input  logic [LINE_W-1:0] vtotal_m1_i,
   input  logic [LINE_W+1:0] exit_len_i,
   input  logic [LINE_W+1:0] earliest_i,
   input  logic [LINE_W+1:0] latest_i,
   input  logic              push_pend_i,
   output logic              consume_o,
   output logic              wrap_o,
   output logic [LINE_W-1:0] line_o,
   output logic              vblank_o,
   output logic              exit_o,
   output logic              latch_o,
   output logic              fs_o,
   output logic              live_o
);
   localparam int EW = LINE_W + 2;

   logic [LINE_W-1:0] line_q;
   logic [EW-1:0]     line_ext, end_q, end_new, end_cmp;
   logic              exit_q, live_q, latch_q, fs_q, go;

   always_comb begin
      line_ext = EW'(line_q);
      if (exit_q)
         go = 1'b0;
      else if (live_q)
         go = (line_ext >= latest_i) || (push_pend_i && (line_ext >= earliest_i));
      else
         go = (line_q >= vbl_start_i);
      end_new = live_q ? (line_ext + exit_len_i - EW'(1)) : EW'(vtotal_m1_i);
      end_cmp = exit_q ? end_q : end_new;
      wrap_o    = tick_i && (exit_q || go) && (line_ext == end_cmp);
      consume_o = go && live_q && push_pend_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         line_q  <= '0;
         end_q   <= '0;
         exit_q  <= 1'b0;
         live_q  <= 1'b0;
         latch_q <= 1'b0;
         fs_q    <= 1'b0;
      end else begin
         latch_q <= go;
         if (wrap_o) begin
            line_q <= '0;
            exit_q <= 1'b0;
            live_q <= vrr_req_i;
            fs_q   <= 1'b1;
         end else begin
            fs_q <= 1'b0;
            if (go) begin
               exit_q <= 1'b1;
               end_q  <= end_new;
            end
            if (tick_i) line_q <= line_q + LINE_W'(1);
         end
      end
   end

   assign line_o   = line_q;
   assign vblank_o = (line_q >= vbl_start_i);
   assign exit_o   = exit_q;
   assign latch_o  = latch_q;
   assign fs_o     = fs_q;
   assign live_o   = live_q;
endmodule

// File: rtl/vrr_vtg.sv
module vrr_vtg
   import vrr_vtg_pkg::*;
#(
   parameter int LINE_W = 12,
   parameter int GB_W   = 8,
   parameter int PF_W   = 9
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              line_tick_i,
   input  logic              cfg_vrr_en_i,
   input  logic              cfg_legacy_i,
   input  logic [LINE_W-1:0] cfg_vbl_start_i,
   input  logic [LINE_W-1:0] cfg_vtotal_m1_i,
   input  logic [LINE_W-1:0] cfg_vmin_m1_i,
   input  logic [LINE_W-1:0] cfg_vmax_m1_i,
   input  logic [LINE_W-1:0] cfg_flip_m1_i,
   input  logic [GB_W-1:0]   cfg_guardband_i,
   input  logic [PF_W-1:0]   cfg_pipe_full_i,
   input  logic [1:0]        cfg_fs_delay_i,
   input  logic              push_wr_i,
   input  logic              push_wr_en_i,
   input  logic              push_wr_send_i,
   output logic [LINE_W-1:0] line_o,
   output logic              vblank_o,
   output logic              vblank_exit_o,
   output logic              frame_start_o,
   output logic              latch_o,
   output logic              vrr_live_o,
   output logic              push_en_o,
   output logic              push_send_o
);
   generate
      if (LINE_W < 4) begin : g_bad_line_w
         $error("vrr_vtg: LINE_W must be at least 4");
      end
      if (GB_W > LINE_W) begin : g_bad_gb_w
         $error("vrr_vtg: GB_W must not exceed LINE_W");
      end
      if (PF_W + 1 > LINE_W) begin : g_bad_pf_w
         $error("vrr_vtg: PF_W must be below LINE_W");
      end
   endgenerate

   logic [LINE_W+1:0] exit_len, earliest, latest;
   logic              push_pend, consume, wrap;
   exit_mode_e        mode;

   assign mode = cfg_legacy_i ? EXIT_LEGACY : EXIT_GUARDBAND;

   vrr_exit_window #(.LINE_W(LINE_W), .GB_W(GB_W), .PF_W(PF_W)) u_win (
      .mode_i      (mode),
      .vmin_m1_i   (cfg_vmin_m1_i),
      .vmax_m1_i   (cfg_vmax_m1_i),
      .flip_m1_i   (cfg_flip_m1_i),
      .guardband_i (cfg_guardband_i),
      .pipe_full_i (cfg_pipe_full_i),
      .fs_delay_i  (cfg_fs_delay_i),
      .exit_len_o  (exit_len),
      .earliest_o  (earliest),
      .latest_o    (latest)
   );

   vrr_push_ctl u_push (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (push_wr_i),
      .wr_en_i   (push_wr_en_i),
      .wr_send_i (push_wr_send_i),
      .consume_i (consume),
      .wrap_i    (wrap),
      .en_o      (push_en_o),
      .send_o    (push_send_o),
      .pending_o (push_pend)
   );

   vrr_line_seq #(.LINE_W(LINE_W)) u_seq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (line_tick_i),
      .vrr_req_i   (cfg_vrr_en_i),
      .vbl_start_i (cfg_vbl_start_i),
      .vtotal_m1_i (cfg_vtotal_m1_i),
      .exit_len_i  (exit_len),
      .earliest_i  (earliest),
      .latest_i    (latest),
      .push_pend_i (push_pend),
      .consume_o   (consume),
      .wrap_o      (wrap),
      .line_o      (line_o),
      .vblank_o    (vblank_o),
      .exit_o      (vblank_exit_o),
      .latch_o     (latch_o),
      .fs_o        (frame_start_o),
      .live_o      (vrr_live_o)
   );
endmodule

// File: rtl/vrr_vtg_chk.sv
module vrr_vtg_chk #(
   parameter int LINE_W = 12
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              push_wr_i,
   input logic [LINE_W-1:0] cfg_vtotal_m1_i,
   input logic [LINE_W-1:0] cfg_vmax_m1_i,
   input logic [LINE_W-1:0] line_o,
   input logic              vblank_exit_o,
   input logic              frame_start_o,
   input logic              latch_o,
   input logic              vrr_live_o,
   input logic              push_en_o,
   input logic              push_send_o
);
   assert_fs_line_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_start_o |-> (line_o == '0));

   assert_latch_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      latch_o |=> !latch_o);

   assert_latch_in_exit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      latch_o |-> vblank_exit_o);

   assert_live_at_fs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frame_start_o |-> $stable(vrr_live_o));

   assert_send_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(push_send_o) |-> (frame_start_o || $past(push_wr_i)));

   assert_send_needs_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_send_o |-> push_en_o);

   assert_vmax_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vrr_live_o |-> (line_o <= cfg_vmax_m1_i));

   assert_fixed_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vrr_live_o |-> (line_o <= cfg_vtotal_m1_i));
endmodule

bind vrr_vtg vrr_vtg_chk #(.LINE_W(LINE_W)) u_chk (
   .clk_i           (clk_i),
   .rst_ni          (rst_ni),
   .push_wr_i       (push_wr_i),
   .cfg_vtotal_m1_i (cfg_vtotal_m1_i),
   .cfg_vmax_m1_i   (cfg_vmax_m1_i),
   .line_o          (line_o),
   .vblank_exit_o   (vblank_exit_o),
   .frame_start_o   (frame_start_o),
   .latch_o         (latch_o),
   .vrr_live_o      (vrr_live_o),
   .push_en_o       (push_en_o),
   .push_send_o     (push_send_o)
);

// File: tb/vrr_vtg_tb.sv
module vrr_vtg_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LINE_W = 12;
   localparam int GB_W = 8;
   localparam int PF_W = 9;
   localparam int TICK_DIV = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick = 1'b0;
   logic              vrr_en = 1'b0;
   logic              legacy = 1'b0;
   logic [LINE_W-1:0] vbl_start = 12'd20;
   logic [LINE_W-1:0] vtotal_m1 = 12'd29;
   logic [LINE_W-1:0] vmin_m1 = 12'd29;
   logic [LINE_W-1:0] vmax_m1 = 12'd59;
   logic [LINE_W-1:0] flip_m1 = 12'd30;
   logic [GB_W-1:0]   guardband = 8'd6;
   logic [PF_W-1:0]   pipe_full = 9'd10;
   logic [1:0]        fs_delay = 2'd1;
   logic              push_wr = 1'b0;
   logic              push_wr_en = 1'b0;
   logic              push_wr_send = 1'b0;
   logic [LINE_W-1:0] line;
   logic              vblank, vexit, fs, latch, live, push_en, push_send;

   int n_checks = 0;
   int n_fail = 0;
   int exp_tot_q[$];
   int exp_lat_q[$];
   string exp_tag_q[$];
   int prev_line = 0;
   int lat_line = -1;

   always #(CLK_PERIOD/2) clk = ~clk;

   vrr_vtg #(.LINE_W(LINE_W), .GB_W(GB_W), .PF_W(PF_W)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .line_tick_i(tick),
      .cfg_vrr_en_i(vrr_en), .cfg_legacy_i(legacy),
      .cfg_vbl_start_i(vbl_start), .cfg_vtotal_m1_i(vtotal_m1),
      .cfg_vmin_m1_i(vmin_m1), .cfg_vmax_m1_i(vmax_m1), .cfg_flip_m1_i(flip_m1),
      .cfg_guardband_i(guardband), .cfg_pipe_full_i(pipe_full), .cfg_fs_delay_i(fs_delay),
      .push_wr_i(push_wr), .push_wr_en_i(push_wr_en), .push_wr_send_i(push_wr_send),
      .line_o(line), .vblank_o(vblank), .vblank_exit_o(vexit), .frame_start_o(fs),
      .latch_o(latch), .vrr_live_o(live), .push_en_o(push_en), .push_send_o(push_send)
   );

   initial begin
      int div = 0;
      forever begin
         @(negedge clk);
         div = div + 1;
         tick = rst_n && (div % TICK_DIV == 0);
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor: compares each finished frame with the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (latch) lat_line = int'(line);
         if (fs) begin
            if (exp_tot_q.size() > 0) begin
               string tg;
               int et, el;
               et = exp_tot_q.pop_front();
               el = exp_lat_q.pop_front();
               tg = exp_tag_q.pop_front();
               check({tg, " frame total"}, prev_line + 1, et);
               check({tg, " latch line"}, lat_line, el);
               check("R11 line zero at frame start", int'(line), 0);
            end
            lat_line = -1;
         end
         prev_line = int'(line);
      end
   end

   task automatic expect_frame(input int tot, input int lat, input string tag);
      exp_tot_q.push_back(tot);
      exp_lat_q.push_back(lat);
      exp_tag_q.push_back(tag);
   endtask

   task automatic wait_fs();
      do @(negedge clk); while (!fs);
   endtask

   task automatic wait_line(input int l);
      while (int'(line) != l) @(negedge clk);
   endtask

   task automatic do_push(input logic en, input logic send);
      @(negedge clk);
      push_wr = 1'b1; push_wr_en = en; push_wr_send = send;
      @(negedge clk);
      push_wr = 1'b0; push_wr_en = 1'b0; push_wr_send = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 line in reset", int'(line), 0);
      check("R1 strobes in reset", int'({fs, latch, vblank, vexit}), 0);
      check("R1 live/push in reset", int'({live, push_en, push_send}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", int'({fs, latch, live, push_en, push_send}), 0);

      // frame 1: fixed mode, a push is written but must not matter (R10)
      expect_frame(30, 20, "R2 R10 fixed");
      wait_line(5);
      do_push(1'b1, 1'b1);
      wait_line(19);
      check("R2 vblank low before start", int'(vblank), 0);
      wait_line(20);
      check("R2 vblank high at start", int'(vblank), 1);
      wait_fs();
      check("R10 send kept in fixed", int'(push_send), 1);

      // frame 2: enable requested mid-frame (R9)
      expect_frame(30, 20, "R9 pending enable");
      wait_line(10);
      vrr_en = 1'b1;
      wait_line(15);
      check("R9 live waits for frame start", int'(live), 0);
      wait_fs();
      check("R9 live at frame start", int'(live), 1);

      // frame 3: push held from before, exit at earliest 31-6=25 (R5, R3)
      expect_frame(31, 25, "R5 R3 held push");
      wait_fs();
      check("R8 send cleared by consuming frame", int'(push_send), 0);
      check("R8 enable kept", int'(push_en), 1);

      // frame 4: no push, exit at 60-6=54 (R4)
      expect_frame(60, 54, "R4 no push");
      wait_fs();

      // frame 5: push at line 40 inside window (R6)
      expect_frame(46, 40, "R6 push in window");
      wait_line(40);
      do_push(1'b1, 1'b1);
      wait_fs();

      // frame 6: push after exit started stays pending (R8)
      expect_frame(60, 54, "R8 late push");
      wait_line(57);
      do_push(1'b1, 1'b1);
      wait_fs();
      check("R8 late push still pending", int'(push_send), 1);

      // frame 7: late push used at earliest line
      expect_frame(31, 25, "R8 R5 carried push");
      wait_fs();

      // frame 8: flip line 41 above vmin+1, earliest 41-6=35 (R3)
      flip_m1 = 12'd40;
      expect_frame(41, 35, "R3 flip line");
      wait_line(2);
      do_push(1'b1, 1'b1);
      wait_fs();

      // frame 9: legacy, len = 10+1+2 = 13, latest 60-13=47 (R7)
      flip_m1 = 12'd30;
      legacy = 1'b1;
      expect_frame(60, 47, "R7 legacy latest");
      wait_fs();

      // frame 10: legacy early push, earliest 31-13=18 (R7, R5)
      expect_frame(31, 18, "R7 legacy earliest");
      wait_line(3);
      do_push(1'b1, 1'b1);
      wait_fs();

      // frame 11: pipeline fill 300 capped to 255, len 258, latest 401-258=143 (R7)
      pipe_full = 9'd300;
      vmax_m1 = 12'd400;
      expect_frame(401, 143, "R7 pipe cap");
      wait_fs();

      // frame 12: disable mid-frame (R9)
      pipe_full = 9'd10;
      vmax_m1 = 12'd59;
      expect_frame(60, 47, "R9 pending disable");
      wait_line(5);
      vrr_en = 1'b0;
      wait_line(10);
      check("R9 live stays until frame start", int'(live), 1);
      wait_fs();
      check("R9 live cleared at frame start", int'(live), 0);
      do_push(1'b0, 1'b0);
      check("R8 zero write clears push", int'({push_en, push_send}), 0);

      // frame 13: back to fixed
      expect_frame(30, 20, "R2 fixed again");
      wait_line(21);
      check("R11 exit flag in vblank", int'(vexit), 1);
      wait_fs();

      @(negedge clk);
      check("R11 frame start single cycle", int'(fs), 0);
      check("scoreboard drained", exp_tot_q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule